// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets synchronous on-chip logic use an external asynchronous static RAM of 32K words by 8 bits. The user side offers a single-word request port: an address, a write flag, write data and a request strobe. A ready output tells the user when a new request may be issued. Read results come back on a data output together with a one-clock valid pulse.

The memory side drives a 15-bit address and three active-low strobes: chip select, write strobe and output strobe. The 8-bit bidirectional data bus is split into an output value, an output-drive enable and an input value, and the pad is built around the block. The memory's nanosecond limits are given as picosecond parameters together with the clock period. Every access phase is held for the ceiling of the limit divided by the period, and never less than one cycle.

When a write follows a read, the block waits before it turns the bus around. Its drivers stay off until the memory has had its worst-case release time after the output strobe rises. All strobes and the drive enable come straight from flip-flops, so they cannot glitch.

Top module: `sram_async_ctl`

## Requirements
- R1: After reset, ready is 1, rvalid is 0, mem_ce_n, mem_we_n and mem_oe_n are all 1, and mem_dq_oe is 0.
- R2: An accepted read (req=1, req_wr=0 while ready=1 at a rising edge) holds mem_ce_n=0, mem_oe_n=0 and mem_we_n=1 with mem_addr equal to the request address for exactly RD_CYC cycles. RD_CYC is 11 at the default 5000 ps clock.
- R3: A read samples mem_dq_i on the last cycle of its access phase. At the edge that ends the phase, rdata shows that value and rvalid goes to 1 for exactly one cycle, while the strobes return high.
- R4: An accepted write holds mem_ce_n=0, mem_we_n=0 and mem_oe_n=1 for exactly WR_CYC cycles (11 at default). mem_dq_oe=1 and mem_dq_o holds the request data throughout, and the drive enable falls at the same edge as mem_we_n rises.
- R5: ready falls at the edge that accepts a request and stays 0 until the edge that ends the access. A req raised while ready=0 is ignored and changes neither mem_addr nor the memory contents.
- R6: When a write follows a read, mem_dq_oe and mem_we_n stay deasserted until mem_oe_n has been high for at least TURN_CYC cycles (4 at default, 20 ns). With no pause between the requests, the drive enable rises exactly 20 ns after mem_oe_n rises.
- R7: mem_we_n and mem_oe_n are never low together. mem_dq_oe is 1 only while mem_we_n and mem_ce_n are low. With mem_ce_n=1 both other strobes are high.
- R8: Every phase length is max(1, ceil(limit_ps / CLK_PS)). The read phase covers the read cycle and access limits, and the write phase covers the cycle, pulse, address-to-end and data-setup limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe, accepted when ready is 1 |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write data |
| ready | output | 1 | Controller idle and able to accept a request |
| rdata | output | 8 | Captured read data |
| rvalid | output | 1 | One-cycle pulse when rdata is updated |
| mem_addr | output | 15 | Memory address |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output strobe, active low |
| mem_dq_o | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 8 | Data received from the memory |

## Verification
A request is accepted at rising edge P1, and the strobes change at that same edge. The read strobes are therefore low over the RD_CYC negative edges that follow P1. rdata, rvalid and ready are due at the edge P1+RD_CYC, and a write releases the bus at P1+WR_CYC. The bench drives inputs and samples outputs on falling edges, checking every cycle inside each window and the cycle just past it. The turnaround case is timed with real time from the rise of the output strobe to the rise of the drive enable. The expected 20 ns follows from requesting the write directly after the read returns.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_HOLD  = 2'd2,
    ST_WRITE = 2'd3
  } ctl_state_e;

  // Clock cycles needed to cover a time limit, never fewer than one.
  function automatic int cycles_for(input int limit_ps, input int clk_ps);
    int c;
    c = (limit_ps + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_rst_sync.sv
`timescale 1ns/1ps
module sram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_s = sync_q;
endmodule

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_turn_guard.sv
`timescale 1ns/1ps
module sram_turn_guard #(
  parameter int TURN_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_n,
  input  logic oe_n_nxt,
  input  logic drv_en,
  output logic ok
);
  localparam int TW = $clog2(TURN_CYC + 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          release_ev;
  logic          cnt_en;

  always_comb begin
    release_ev = oe_n_nxt && !oe_n;
    cnt_en     = release_ev || (cnt_q != '0);
    if (release_ev) cnt_d = TW'(TURN_CYC);
    else            cnt_d = cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // Drivers may switch on at the next edge once this edge completes the gap.
  assign ok = (cnt_q <= TW'(1));

  // Independent measure of how long the output strobe has been high.
  logic [TW-1:0] hi_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      hi_q <= TW'(TURN_CYC);
    else if (!oe_n)                  hi_q <= '0;
    else if (hi_q != TW'(TURN_CYC))  hi_q <= hi_q + TW'(1);
  end

  assert_turn_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en) |-> (hi_q >= TW'(TURN_CYC)));

endmodule

// File: rtl/sram_async_ctl.sv
`timescale 1ns/1ps
module sram_async_ctl
  import sram_ctl_pkg::*;
#(
  parameter int AW        = 15,
  parameter int DW        = 8,
  parameter int CLK_PS    = 5000,
  parameter int T_RC_PS   = 55000,
  parameter int T_AA_PS   = 55000,
  parameter int T_OE_PS   = 30000,
  parameter int T_WC_PS   = 55000,
  parameter int T_WP_PS   = 45000,
  parameter int T_AW_PS   = 50000,
  parameter int T_DW_PS   = 25000,
  parameter int T_HZ_PS   = 20000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ready,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);
  localparam int RD_CYC   = cycles_for(max2(max2(T_RC_PS, T_AA_PS), T_OE_PS), CLK_PS);
  localparam int WR_CYC   = cycles_for(max2(max2(T_WC_PS, T_WP_PS),
                                            max2(T_AW_PS, T_DW_PS)), CLK_PS);
  localparam int TURN_CYC = cycles_for(T_HZ_PS, CLK_PS);
  localparam int MAX_CYC  = max2(RD_CYC, WR_CYC);
  localparam int CW       = $clog2(MAX_CYC + 1);

  logic rst_n_s;
  sram_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  ctl_state_e state_q, state_d;
  logic       accept;
  logic       tmr_load;
  logic [CW-1:0] tmr_val;
  logic       tmr_done;
  logic       turn_ok;

  logic ce_n_d, we_n_d, oe_n_d, dq_oe_d, rvalid_d, capture;

  assign ready  = (state_q == ST_IDLE);
  assign accept = req && ready;

  sram_phase_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n_s), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = CW'(RD_CYC - 1);
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          if (!req_wr) begin
            state_d  = ST_READ;
            tmr_load = 1'b1;
            tmr_val  = CW'(RD_CYC - 1);
          end else if (turn_ok) begin
            state_d  = ST_WRITE;
            tmr_load = 1'b1;
            tmr_val  = CW'(WR_CYC - 1);
          end else begin
            state_d  = ST_HOLD;
          end
        end
      end
      ST_READ:  if (tmr_done) state_d = ST_IDLE;
      ST_HOLD: begin
        if (turn_ok) begin
          state_d  = ST_WRITE;
          tmr_load = 1'b1;
          tmr_val  = CW'(WR_CYC - 1);
        end
      end
      ST_WRITE: if (tmr_done) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // Registered strobe values derived from the coming state
  always_comb begin
    ce_n_d   = !((state_d == ST_READ) || (state_d == ST_WRITE));
    oe_n_d   = (state_d != ST_READ);
    we_n_d   = (state_d != ST_WRITE);
    dq_oe_d  = (state_d == ST_WRITE);
    capture  = (state_q == ST_READ) && tmr_done;
    rvalid_d = capture;
  end

  sram_turn_guard #(.TURN_CYC(TURN_CYC)) u_turn (
    .clk(clk), .rst_n(rst_n_s), .oe_n(mem_oe_n), .oe_n_nxt(oe_n_d),
    .drv_en(mem_dq_oe), .ok(turn_ok)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q   <= ST_IDLE;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      rvalid    <= 1'b0;
    end else begin
      state_q   <= state_d;
      mem_ce_n  <= ce_n_d;
      mem_oe_n  <= oe_n_d;
      mem_we_n  <= we_n_d;
      mem_dq_oe <= dq_oe_d;
      rvalid    <= rvalid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mem_addr <= '0;
      mem_dq_o <= '0;
    end else if (accept) begin
      mem_addr <= req_addr;
      mem_dq_o <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     rdata <= '0;
    else if (capture) rdata <= mem_dq_i;
  end

  // Assertions
  assert_read_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));

  assert_rvalid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    rvalid |=> !rvalid);

  assert_drive_window_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_dq_oe |-> (!mem_we_n && !mem_ce_n && mem_oe_n));

  assert_busy_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req && ready) |=> !ready);

  assert_standby_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_ce_n |-> (mem_we_n && mem_oe_n && !mem_dq_oe));

  logic [CW-1:0] we_lo_q;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)                  we_lo_q <= '0;
    else if (mem_we_n)             we_lo_q <= '0;
    else if (we_lo_q != CW'(WR_CYC)) we_lo_q <= we_lo_q + CW'(1);
  end

  assert_write_width_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(mem_we_n) |-> (we_lo_q >= CW'(WR_CYC)));

endmodule

// File: tb/sram_async_ctl_test.sv
`timescale 1ns/1ps
module sram_async_ctl_test;
  localparam int RD_EXP = 11;
  localparam int WR_EXP = 11;

  logic clk = 1'b0;
  logic rst_n;
  logic req, req_wr;
  logic [14:0] req_addr;
  logic [7:0]  req_wdata;
  logic ready, rvalid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  rdata, mem_dq_o, mem_dq_i;
  logic [14:0] mem_addr;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [7:0] mdl [0:255];
  logic [7:0] exp_mem [0:255];
  realtime t_oe_rise = 0.0;
  realtime drv_gap = 0.0;

  always #2.5 clk = ~clk;

  sram_async_ctl uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .ready(ready), .rdata(rdata), .rvalid(rvalid),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // Memory model
  assign mem_dq_i = (!mem_ce_n && !mem_oe_n && mem_we_n) ? mdl[mem_addr[7:0]] : 8'h00;
  always @(negedge clk)
    if (!mem_ce_n && !mem_we_n && mem_dq_oe) mdl[mem_addr[7:0]] <= mem_dq_o;

  always @(posedge mem_oe_n)  t_oe_rise = $realtime;
  always @(posedge mem_dq_oe) drv_gap = $realtime - t_oe_rise;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(ready == 1'b1 && rvalid == 1'b0, "R1 ready/rvalid", {ready, rvalid}, 2'b10);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 strobes",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
  endtask

  task automatic t_write(input logic [14:0] a, input logic [7:0] d);
    bit ok = 1'b1;
    repeat (5) @(negedge clk);
    req = 1'b1; req_wr = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 1'b0;
    chk(!ready, "R5 ready low after write accept", ready, 0);
    for (int i = 0; i < WR_EXP; i++) begin
      if (!(!mem_ce_n && !mem_we_n && mem_oe_n && mem_dq_oe && mem_dq_o == d && mem_addr == a))
        ok = 1'b0;
      @(negedge clk);
    end
    chk(ok, "R4 write pulse window", mem_addr, a);
    chk(mem_we_n && !mem_dq_oe && ready, "R4 release at end of write",
        {mem_we_n, mem_dq_oe, ready}, 3'b101);
    exp_mem[a[7:0]] = d;
  endtask

  task automatic t_read(input logic [14:0] a);
    bit ok = 1'b1;
    logic [7:0] e;
    e = exp_mem[a[7:0]];
    req = 1'b1; req_wr = 1'b0; req_addr = a;
    @(negedge clk);
    req = 1'b0;
    for (int i = 0; i < RD_EXP; i++) begin
      if (!(!mem_ce_n && !mem_oe_n && mem_we_n && mem_addr == a && !ready && !rvalid))
        ok = 1'b0;
      @(negedge clk);
    end
    chk(ok, "R2 read strobes for RD_CYC cycles", mem_addr, a);
    chk(rvalid && rdata == e, "R3 read data and valid", rdata, e);
    chk(ready && mem_oe_n && mem_ce_n, "R5 ready back at read end", ready, 1);
    @(negedge clk);
    chk(!rvalid, "R3 valid is one cycle", rvalid, 0);
  endtask

  task automatic t_busy_ignore();
    bit ok = 1'b1;
    repeat (5) @(negedge clk);
    req = 1'b1; req_wr = 1'b1; req_addr = 15'h0021; req_wdata = 8'h5A;
    @(negedge clk);
    req_addr = 15'h0066; req_wdata = 8'hC3;
    repeat (3) @(negedge clk);
    req = 1'b0;
    while (!ready) begin
      if (mem_addr != 15'h0021) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok, "R5 busy request leaves address", mem_addr, 15'h0021);
    exp_mem[8'h21] = 8'h5A;
    repeat (2) @(negedge clk);
    t_read(15'h0066);
    t_read(15'h0021);
  endtask

  task automatic t_turnaround();
    t_read(15'h0012);
    req = 1'b1; req_wr = 1'b1; req_addr = 15'h0044; req_wdata = 8'h99;
    @(negedge clk);
    req = 1'b0;
    while (!ready) @(negedge clk);
    chk(drv_gap > 19.99 && drv_gap < 20.01, "R6 drive gap 20 ns",
        int'(drv_gap * 1000.0), 20000);
    exp_mem[8'h44] = 8'h99;
    repeat (2) @(negedge clk);
    t_read(15'h0044);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mdl[i]     = 8'(i * 37 + 5);
      exp_mem[i] = 8'(i * 37 + 5);
    end
    rst_n = 1'b0; req = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write(15'h0012, 8'hA5);
    t_write(15'h7F34, 8'h3C);
    t_read(15'h0012);
    t_read(15'h7F34);
    t_read(15'h4056);
    t_busy_ignore();
    t_turnaround();
    t_write(15'h7FFF, 8'hFF);
    t_write(15'h0000, 8'h00);
    t_read(15'h7FFF);
    t_read(15'h0000);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule